// File: doc/BRIEF.md
# Predicated Element-Step Sequencer

This block steps through the element positions of a vector operation that is gated by a 64-bit predicate. It holds one step register that marks how far the operation has progressed. From that point it finds the lowest element whose predicate bit is set and that lies below the vector length. It reports that element position and an issue group for an ALU that is 64 bits wide and split into lanes. The group has one enable bit per lane. Predicated-off elements inside a group get a disabled lane and are not packed with other elements.

The step register works as a sub-program-counter. An interrupt can happen between any two issues. The saved value can later be written back through the restore input, and the walk then continues from exactly that position. All predicate bits below the step are treated as consumed. They are removed from the search before the lowest set bit is located, so a resumed walk reports the true next position and never restarts at zero.

Each accepted issue (valid and ready together at a clock edge) moves the step to the end of the group just issued. When no eligible bit remains, the block raises its done flag and reports the vector length as the next step.

Top module: `elem_step_seq`

## Requirements
- R1: After a synchronous active-high reset, `cur_step` is 0.
- R2: `next_step` is the lowest index i with `pred_mask[i]`=1, i >= `cur_step` and i < `vec_len`. This is a combinational function of the current inputs and the step register.
- R3: Predicate bits at or above `vec_len` are never reported and never enable a lane. `vec_len` ranges from 0 to 64.
- R4: Predicate bits below `cur_step` count as already processed and are ignored. For example, mask 0x00ffff00 with step 8 gives `next_step`=8, and with step 10 it gives 10.
- R5: When no eligible bit exists, `done`=1, `issue_valid`=0, `next_step`=`vec_len` and `lane_en`=0.
- R6: `ew_sel` sets the lane count: 0 (8-bit elements) gives 8 lanes, 1 gives 4, 2 gives 2 and 3 gives 1. `group_base` is `next_step` rounded down to a multiple of the lane count.
- R7: `lane_en[i]` for i below the lane count is 1 exactly when element `group_base`+i is eligible, meaning its mask bit is set, it is >= `cur_step` and it is < `vec_len`. Lane bits at or above the lane count are 0.
- R8: When `issue_valid` and `issue_ready` are both 1 at a clock edge, `cur_step` becomes `group_base` + lane count. With no accept and no restore, `cur_step` holds.
- R9: When `restore_en`=1 at a clock edge, `cur_step` loads `restore_step`. This takes priority over an accept in the same cycle.
- R10: `issue_valid` is the inverse of `done` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pred_mask | input | 64 | Predicate, one bit per element |
| vec_len | input | 7 | Number of elements in the operation (0..64) |
| ew_sel | input | 2 | Element width select (0:8, 1:16, 2:32, 3:64 bits) |
| restore_en | input | 1 | Load the step register from `restore_step` |
| restore_step | input | 7 | Saved step value to resume from |
| issue_ready | input | 1 | The ALU accepts the current group |
| issue_valid | output | 1 | A group with at least one enabled lane is offered |
| next_step | output | 7 | Next active element position, or `vec_len` when done |
| group_base | output | 7 | First element position of the offered group |
| lane_en | output | 8 | Per-lane enable bits of the offered group |
| done | output | 1 | No eligible element remains |
| cur_step | output | 7 | Step register, readable for saving |

## Verification
A corrupted step register shows up at the ports in the same cycle. `cur_step` is visible directly, and `next_step`, `group_base` and `lane_en` all change combinationally with it. A wrong advance therefore appears one edge after the accept that caused it. A fault in the consumed-bit filter only shows when the walk is resumed from a nonzero or unaligned step: the block either reports a position below the step or enables lanes that were already processed. The resume scenarios use unaligned steps and masks with holes so that such faults show as a wrong `next_step` or `lane_en` right after the restore edge.

// File: rtl/ess_pkg.sv
package ess_pkg;
    localparam int MASK_W    = 64;
    localparam int STEP_W    = $clog2(MASK_W) + 1;
    localparam int MAX_LANES = 8;

    typedef enum logic [1:0] {
        EW_8  = 2'd0,
        EW_16 = 2'd1,
        EW_32 = 2'd2,
        EW_64 = 2'd3
    } ew_e;

    typedef logic [STEP_W-1:0] step_t;

    // One offered issue group
    typedef struct packed {
        logic                 valid;
        step_t                first;
        step_t                base;
        step_t                lanes;
        logic [MAX_LANES-1:0] en;
    } issue_t;

    function automatic step_t lane_count(ew_e ew);
        return step_t'(MAX_LANES >> ew);
    endfunction
endpackage

// File: rtl/ess_eligible.sv
// Keeps only predicate bits in the window [step, vlen)
module ess_eligible #(
    parameter int W  = ess_pkg::MASK_W,
    localparam int SW = $clog2(W) + 1
) (
    input  logic [W-1:0]  mask,
    input  logic [SW-1:0] step,
    input  logic [SW-1:0] vlen,
    output logic [W-1:0]  elig
);
    always_comb begin
        for (int i = 0; i < W; i++) begin
            elig[i] = mask[i] && (SW'(i) >= step) && (SW'(i) < vlen);
        end
    end
endmodule

// File: rtl/ess_tzc.sv
// Trailing-zero count: position of lowest set bit, W when none
module ess_tzc #(
    parameter int W  = ess_pkg::MASK_W,
    localparam int SW = $clog2(W) + 1
) (
    input  logic [W-1:0]  vec,
    output logic [SW-1:0] cnt,
    output logic          any
);
    always_comb begin
        cnt = SW'(W);
        any = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                cnt = SW'(i);
                any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/ess_lane_gen.sv
// Aligns the group to the lane count and extracts per-lane enables
module ess_lane_gen
    import ess_pkg::*;
#(
    parameter int W  = ess_pkg::MASK_W,
    parameter int L  = ess_pkg::MAX_LANES,
    localparam int SW = $clog2(W) + 1,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  elig,
    input  logic [SW-1:0] first,
    input  ew_e           ew,
    output logic [SW-1:0] base,
    output logic [SW-1:0] lanes,
    output logic [L-1:0]  en
);
    logic [SW-1:0] idx;

    always_comb begin
        lanes = SW'(lane_count(ew));
        base  = first & ~(lanes - SW'(1));
        idx   = '0;
        en    = '0;
        for (int i = 0; i < L; i++) begin
            idx = base + SW'(i);
            if ((SW'(i) < lanes) && (idx < SW'(W))) begin
                en[i] = elig[idx[IW-1:0]];
            end
        end
    end
endmodule

// File: rtl/elem_step_seq.sv
module elem_step_seq
    import ess_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [MASK_W-1:0]    pred_mask,
    input  logic [STEP_W-1:0]    vec_len,
    input  logic [1:0]           ew_sel,
    input  logic                 restore_en,
    input  logic [STEP_W-1:0]    restore_step,
    input  logic                 issue_ready,
    output logic                 issue_valid,
    output logic [STEP_W-1:0]    next_step,
    output logic [STEP_W-1:0]    group_base,
    output logic [MAX_LANES-1:0] lane_en,
    output logic                 done,
    output logic [STEP_W-1:0]    cur_step
);
    step_t             step_q;
    logic [MASK_W-1:0] elig;
    step_t             tz_cnt;
    logic              tz_any;
    issue_t            iss;
    ew_e               ew;

    assign ew = ew_e'(ew_sel);

    ess_eligible #(.W(MASK_W)) u_elig (
        .mask (pred_mask),
        .step (step_q),
        .vlen (vec_len),
        .elig (elig)
    );

    ess_tzc #(.W(MASK_W)) u_tzc (
        .vec (elig),
        .cnt (tz_cnt),
        .any (tz_any)
    );

    assign iss.valid = tz_any;
    assign iss.first = tz_any ? tz_cnt : vec_len;

    ess_lane_gen #(.W(MASK_W), .L(MAX_LANES)) u_lanes (
        .elig  (elig),
        .first (iss.first),
        .ew    (ew),
        .base  (iss.base),
        .lanes (iss.lanes),
        .en    (iss.en)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q <= '0;
        end else if (restore_en) begin
            step_q <= restore_step;
        end else if (iss.valid && issue_ready) begin
            step_q <= iss.base + iss.lanes;
        end
    end

    assign issue_valid = iss.valid;
    assign done        = !iss.valid;
    assign next_step   = iss.first;
    assign group_base  = iss.base;
    assign lane_en     = iss.en;
    assign cur_step    = step_q;
endmodule

// File: rtl/ess_checker.sv
module ess_checker
    import ess_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic [MASK_W-1:0]    pred_mask,
    input logic [STEP_W-1:0]    vec_len,
    input logic [1:0]           ew_sel,
    input logic                 restore_en,
    input logic [STEP_W-1:0]    restore_step,
    input logic                 issue_ready,
    input logic                 issue_valid,
    input logic [STEP_W-1:0]    next_step,
    input logic [STEP_W-1:0]    group_base,
    input logic [MAX_LANES-1:0] lane_en,
    input logic                 done,
    input logic [STEP_W-1:0]    cur_step
);
    step_t lanes;
    step_t offs;
    assign lanes = lane_count(ew_e'(ew_sel));
    assign offs  = next_step - group_base;

    assert_found_in_window_R2: assert property (@(posedge clk) disable iff (rst)
        issue_valid |-> (next_step >= cur_step && next_step < vec_len
                         && pred_mask[next_step[STEP_W-2:0]]));

    assert_done_outputs_R5: assert property (@(posedge clk) disable iff (rst)
        done |-> (next_step == vec_len && lane_en == '0 && !issue_valid));

    assert_group_aligned_R6: assert property (@(posedge clk) disable iff (rst)
        issue_valid |-> (group_base <= next_step && offs < lanes
                         && (group_base & (lanes - step_t'(1))) == '0));

    assert_first_lane_on_R7: assert property (@(posedge clk) disable iff (rst)
        issue_valid |-> (lane_en[offs[2:0]] && $countones(lane_en) <= int'(lanes)));

    assert_advance_R8: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && issue_ready && !restore_en)
            |=> cur_step == $past(group_base) + $past(lanes));

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!restore_en && !(issue_valid && issue_ready)) |=> $stable(cur_step));

    assert_restore_R9: assert property (@(posedge clk) disable iff (rst)
        restore_en |=> cur_step == $past(restore_step));
endmodule

bind elem_step_seq ess_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .pred_mask    (pred_mask),
    .vec_len      (vec_len),
    .ew_sel       (ew_sel),
    .restore_en   (restore_en),
    .restore_step (restore_step),
    .issue_ready  (issue_ready),
    .issue_valid  (issue_valid),
    .next_step    (next_step),
    .group_base   (group_base),
    .lane_en      (lane_en),
    .done         (done),
    .cur_step     (cur_step)
);

// File: tb/elem_step_seq_tb.sv
module elem_step_seq_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [63:0] pred_mask;
    logic [6:0]  vec_len;
    logic [1:0]  ew_sel;
    logic        restore_en;
    logic [6:0]  restore_step;
    logic        issue_ready;
    logic        issue_valid;
    logic [6:0]  next_step;
    logic [6:0]  group_base;
    logic [7:0]  lane_en;
    logic        done;
    logic [6:0]  cur_step;

    int checks = 0;
    int failures = 0;
    logic [6:0] exp_step;

    always #(CLK_PERIOD/2) clk = ~clk;

    elem_step_seq u_dut (
        .clk(clk), .rst(rst), .pred_mask(pred_mask), .vec_len(vec_len),
        .ew_sel(ew_sel), .restore_en(restore_en), .restore_step(restore_step),
        .issue_ready(issue_ready), .issue_valid(issue_valid),
        .next_step(next_step), .group_base(group_base), .lane_en(lane_en),
        .done(done), .cur_step(cur_step)
    );

    // Independent model of the requirements
    task automatic model(output logic v, output logic [6:0] ns,
                         output logic [6:0] gb, output logic [7:0] le,
                         output int lanes);
        lanes = 8 >> ew_sel;
        v  = 1'b0;
        ns = vec_len;
        for (int i = 63; i >= 0; i--) begin
            if (pred_mask[i] && i >= int'(exp_step) && i < int'(vec_len)) begin
                ns = 7'(i);
                v  = 1'b1;
            end
        end
        gb = 7'((int'(ns) / lanes) * lanes);
        le = '0;
        for (int i = 0; i < 8; i++) begin
            int idx = int'(gb) + i;
            if (i < lanes && idx < 64 && idx >= int'(exp_step)
                && idx < int'(vec_len) && pred_mask[idx])
                le[i] = 1'b1;
        end
    endtask

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_all(string req);
        logic v; logic [6:0] ns, gb; logic [7:0] le; int lanes;
        model(v, ns, gb, le, lanes);
        chk(req, "cur_step", int'(cur_step), int'(exp_step));
        chk(req, "issue_valid", int'(issue_valid), int'(v));
        chk(req, "done(R10)", int'(done), int'(!v));
        chk(req, "next_step", int'(next_step), int'(ns));
        chk(req, "group_base", int'(group_base), int'(gb));
        chk(req, "lane_en", int'(lane_en), int'(le));
    endtask

    // One clock edge; updates the expected step from the requirements
    task automatic tick();
        logic v; logic [6:0] ns, gb; logic [7:0] le; int lanes;
        model(v, ns, gb, le, lanes);
        @(posedge clk);
        if (restore_en) exp_step = restore_step;
        else if (v && issue_ready) exp_step = 7'(int'(gb) + lanes);
        @(negedge clk);
        #1;
    endtask

    task automatic do_restore(logic [6:0] s);
        restore_en = 1'b1; restore_step = s;
        tick();
        restore_en = 1'b0;
        #1;
    endtask

    task automatic walk(string req, int limit);
        issue_ready = 1'b1;
        for (int k = 0; k < limit; k++) begin
            #1 check_all(req);
            if (done) break;
            tick();
        end
        issue_ready = 1'b0;
    endtask

    task automatic t_reset();
        pred_mask = '0; vec_len = 7'd64; ew_sel = 2'd0;
        #1 chk("R1", "cur_step after reset", int'(cur_step), 0);
        check_all("R5");
    endtask

    task automatic t_fresh_ew8();
        pred_mask = 64'h0000_0000_00ff_ff00; vec_len = 7'd64; ew_sel = 2'd0;
        #1 chk("R2", "first next_step", int'(next_step), 8);
        chk("R7", "first lane_en", int'(lane_en), 8'hff);
        walk("R8", 20);
        chk("R5", "final next_step", int'(next_step), 64);
    endtask

    task automatic t_resume_example();
        pred_mask = 64'h0000_0000_00ff_ff00; vec_len = 7'd64; ew_sel = 2'd3;
        do_restore(7'd8);
        chk("R4", "resume at 8", int'(next_step), 8);
        check_all("R9");
        do_restore(7'd10);
        chk("R4", "resume at 10", int'(next_step), 10);
        do_restore(7'd30);
        chk("R5", "resume past end done", int'(done), 1);
        check_all("R5");
    endtask

    task automatic t_unaligned_ew8();
        pred_mask = '1; vec_len = 7'd64; ew_sel = 2'd0;
        do_restore(7'd3);
        chk("R4", "unaligned lane_en", int'(lane_en), 8'hf8);
        chk("R6", "unaligned base", int'(group_base), 0);
        walk("R8", 20);
    endtask

    task automatic t_vlen_limit();
        pred_mask = '1; vec_len = 7'd5; ew_sel = 2'd0;
        do_restore(7'd0);
        chk("R3", "vl lane_en", int'(lane_en), 8'h1f);
        walk("R3", 5);
        chk("R3", "vl done next_step", int'(next_step), 5);
    endtask

    task automatic t_holes_ew16();
        pred_mask = 64'hA5A5_0000_1234_8001; vec_len = 7'd60; ew_sel = 2'd1;
        do_restore(7'd0);
        walk("R7", 40);
        ew_sel = 2'd2;
        pred_mask = 64'h8000_0000_0000_0001; vec_len = 7'd64;
        do_restore(7'd0);
        walk("R6", 10);
    endtask

    task automatic t_stall_and_priority();
        pred_mask = 64'h0000_0000_0000_0ff0; vec_len = 7'd64; ew_sel = 2'd1;
        do_restore(7'd0);
        issue_ready = 1'b0;
        for (int k = 0; k < 3; k++) begin
            tick();
            chk("R8", "stall holds step", int'(cur_step), 0);
        end
        issue_ready = 1'b1; restore_en = 1'b1; restore_step = 7'd9;
        tick();
        restore_en = 1'b0; issue_ready = 1'b0;
        #1 chk("R9", "restore beats accept", int'(cur_step), 9);
        check_all("R9");
        pred_mask = '0;
        #1 chk("R5", "empty mask done", int'(done), 1);
        check_all("R5");
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; pred_mask = '0; vec_len = 7'd64; ew_sel = 2'd0;
        restore_en = 1'b0; restore_step = '0; issue_ready = 1'b0;
        exp_step = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_fresh_ew8();
        t_resume_example();
        t_unaligned_ew8();
        t_vlen_limit();
        t_holes_ew16();
        t_stall_and_priority();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule